// File: doc/BRIEF.md
# Segment Register Descriptor Loader

The block holds six segment registers. Each register has a 16-bit selector that software can see and a hidden cache that holds the descriptor fields of the active segment. A selector write does more than store a value. In protected mode, the block decodes the selector and chooses the global or the local descriptor table. It then fetches the 8-byte descriptor as two 32-bit reads over a simple request/valid read port. It checks the presence and privilege fields, and only then updates the selector and the cache together. If a check fails, it raises a one-cycle fault and leaves the register untouched.

In real mode, a selector write fills the cache in a single cycle, with base equal to the selector times 16 and a 64 KB limit. No memory is read.

The cached fields of every register are driven out in parallel. The consumers are address generation and protection logic downstream.

Top module: `seg_loader`

## Requirements
- R1: After reset, every selector and every cached field reads zero, and busy, fault and rd_req are low.
- R2: Selector bits [15:3] are the index, bit 2 chooses the table (1 = global, 0 = local) and bits [1:0] are the requestor level. The first read address is the chosen table base plus index times 8.
- R3: The second read address is the first read address plus 4. The first read returns descriptor bytes 0..3 and the second returns bytes 4..7.
- R4: The cache is filled as follows. Limit is {hi[19:16], lo[15:0]}. Base is {hi[31:24], hi[7:0], lo[31:16]}. Type is hi[11:8], S is hi[12], DPL is hi[14:13] and present is hi[15]. The two extra bits are hi[21:20], D/B is hi[22] and granularity is hi[23].
- R5: busy is high from the cycle after an accepted protected-mode write until the cycle after the second read returns. A write presented while busy is ignored.
- R6: A descriptor with its present bit clear gives a one-cycle fault in the cycle after the second read. That register's selector and cache stay unchanged.
- R7: A data-segment descriptor (S = 1 and type bit 3 = 0) whose DPL is numerically smaller than the selector's requestor level faults in the same way. Code and system descriptors are not checked for privilege.
- R8: A real-mode write updates the register in the next cycle. The cache gets base = selector << 4, limit 0x0FFFF, G = 0, D/B = 0, S = 1, DPL 0, type 4'b0011, extra bits 0 and present 1. No read is issued and busy stays low.
- R9: A load changes only the addressed register. Other registers keep their contents.
- R10: A write whose segment number is 6 or 7 is ignored: no read, no busy and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| real_mode | input | 1 | 1 = real-mode direct load |
| wr_en | input | 1 | Selector write strobe |
| wr_seg | input | 3 | Segment register number |
| wr_sel | input | 16 | Selector value written |
| gdt_base | input | 32 | Global table base address |
| ldt_base | input | 32 | Local table base address |
| rd_req | output | 1 | Read request, held until rd_valid |
| rd_addr | output | 32 | Read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| busy | output | 1 | Descriptor fetch in progress |
| fault | output | 1 | One-cycle load fault pulse |
| sel_o | output | 6x16 | Selectors |
| base_o | output | 6x32 | Cached bases |
| limit_o | output | 6x20 | Cached limits |
| gran_o | output | 6 | Cached granularity bits |
| db_o | output | 6 | Cached D/B bits |
| app_o | output | 6 | Cached S bits |
| dpl_o | output | 6x2 | Cached descriptor privilege levels |
| type_o | output | 6x4 | Cached type fields |
| present_o | output | 6 | Cached present bits |
| ext_o | output | 6x2 | Cached extra bits hi[21:20] |

## Verification
Two events can fall on the same edge: a new selector write, and the completion of the second descriptor read. When they coincide, the completion must win and the write must be dropped. To provoke this, the bench presents a random write on every cycle while busy is high, including the cycle in which the last read returns. The memory model varies its latency at random so that this cycle moves around. The bench then checks that the register holds the descriptor of the original selector and that the fault flag matches the original load's checks.

// File: rtl/seg_pkg.sv
// Shared types for the segment descriptor loader.
// Assumes one cache entry per segment register and a fixed field set.
package seg_pkg;
    typedef struct packed {
        logic [31:0] base;
        logic [19:0] limit;
        logic        gran;
        logic        db;
        logic        app;
        logic [1:0]  dpl;
        logic [3:0]  typ;
        logic        present;
        logic [1:0]  ext;
    } seg_cache_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RD_LO = 2'd1,
        ST_RD_HI = 2'd2
    } fetch_state_t;
endpackage

// File: rtl/seg_sel_decode.sv
// Selector decoder: splits a selector into index, table choice and
// requestor level, and forms the descriptor address.
// Assumes descriptors of 8 bytes and selectors of SEL_W bits.
module seg_sel_decode #(
    parameter int SEL_W  = 16,
    parameter int ADDR_W = 32
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [ADDR_W-1:0] gdt_base,
    input  logic [ADDR_W-1:0] ldt_base,
    output logic [ADDR_W-1:0] desc_addr,
    output logic [1:0]        rpl
);
    localparam int IDX_W = SEL_W - 3;

    logic [IDX_W-1:0]  index;
    logic [ADDR_W-1:0] offset;

    // Field split and table-relative address
    always_comb begin
        index     = sel[SEL_W-1:3];
        rpl       = sel[1:0];
        offset    = ADDR_W'({index, 3'b000});
        desc_addr = (sel[2] ? gdt_base : ldt_base) + offset;
    end
endmodule

// File: rtl/seg_desc_unpack.sv
// Descriptor unpacker and checker: builds a cache entry from the two
// descriptor words and decides whether the load may complete.
// Assumes the split layout: low word = bytes 0..3, high word = bytes 4..7.
module seg_desc_unpack
    import seg_pkg::*;
(
    input  logic [31:0] w_lo,
    input  logic [31:0] w_hi,
    input  logic [1:0]  rpl,
    output seg_cache_t  entry,
    output logic        ok
);
    logic is_data;

    // Field extraction from the split layout
    always_comb begin
        entry.base    = {w_hi[31:24], w_hi[7:0], w_lo[31:16]};
        entry.limit   = {w_hi[19:16], w_lo[15:0]};
        entry.gran    = w_hi[23];
        entry.db      = w_hi[22];
        entry.ext     = w_hi[21:20];
        entry.present = w_hi[15];
        entry.dpl     = w_hi[14:13];
        entry.app     = w_hi[12];
        entry.typ     = w_hi[11:8];
    end

    // Presence and data-segment privilege check
    always_comb begin
        is_data = entry.app && !entry.typ[3];
        ok      = entry.present && !(is_data && (rpl > entry.dpl));
    end
endmodule

// File: rtl/seg_fetch_ctrl.sv
// Fetch controller: accepts selector writes, runs the two-read descriptor
// fetch, and issues one commit or one fault per accepted write.
// Assumes rd_valid is only given while rd_req is high; busy writes are dropped.
module seg_fetch_ctrl
    import seg_pkg::*;
#(
    parameter int NSEG   = 6,
    parameter int SEG_W  = 3,
    parameter int SEL_W  = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              real_mode,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_seg,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [ADDR_W-1:0] gdt_base,
    input  logic [ADDR_W-1:0] ldt_base,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [31:0]       rd_data,
    output logic              busy,
    output logic              fault,
    output logic              cw_en,
    output logic [SEG_W-1:0]  cw_seg,
    output logic [SEL_W-1:0]  cw_sel,
    output seg_cache_t        cw_entry
);
    localparam int LIM_HI = 20;

    fetch_state_t      state_q;
    logic [SEG_W-1:0]  seg_q;
    logic [SEL_W-1:0]  sel_q;
    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       lo_q;
    logic [ADDR_W-1:0] dec_addr;
    logic [1:0]        dec_rpl;
    logic [1:0]        rpl_q;
    logic              accept;
    logic              last_rd;
    seg_cache_t        fetched;
    seg_cache_t        real_entry;
    logic              desc_ok;

    seg_sel_decode #(.SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_dec (
        .sel       (wr_sel),
        .gdt_base  (gdt_base),
        .ldt_base  (ldt_base),
        .desc_addr (dec_addr),
        .rpl       (dec_rpl)
    );

    seg_desc_unpack u_unpack (
        .w_lo  (lo_q),
        .w_hi  (rd_data),
        .rpl   (rpl_q),
        .entry (fetched),
        .ok    (desc_ok)
    );

    // Write acceptance and final-read detection
    always_comb begin
        accept  = wr_en && (state_q == ST_IDLE) && (wr_seg < SEG_W'(NSEG));
        last_rd = (state_q == ST_RD_HI) && rd_valid;
    end

    // Real-mode cache entry built from the selector
    always_comb begin
        real_entry         = '0;
        real_entry.base    = ADDR_W'({wr_sel, 4'b0000});
        real_entry.limit   = LIM_HI'(20'h0FFFF);
        real_entry.app     = 1'b1;
        real_entry.typ     = 4'b0011;
        real_entry.present = 1'b1;
    end

    // Read port drive
    always_comb begin
        rd_req  = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
        rd_addr = (state_q == ST_RD_HI) ? addr_q + ADDR_W'(4) : addr_q;
        busy    = (state_q != ST_IDLE);
    end

    // Commit path to the register file
    always_comb begin
        cw_en    = (accept && real_mode) || (last_rd && desc_ok);
        cw_seg   = last_rd ? seg_q : wr_seg;
        cw_sel   = last_rd ? sel_q : wr_sel;
        cw_entry = last_rd ? fetched : real_entry;
    end

    // Fetch sequencing and fault pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            seg_q   <= '0;
            sel_q   <= '0;
            addr_q  <= '0;
            lo_q    <= '0;
            rpl_q   <= '0;
            fault   <= 1'b0;
        end else begin
            fault <= last_rd && !desc_ok;
            case (state_q)
                ST_IDLE: if (accept && !real_mode) begin
                    seg_q   <= wr_seg;
                    sel_q   <= wr_sel;
                    addr_q  <= dec_addr;
                    rpl_q   <= dec_rpl;
                    state_q <= ST_RD_LO;
                end
                ST_RD_LO: if (rd_valid) begin
                    lo_q    <= rd_data;
                    state_q <= ST_RD_HI;
                end
                ST_RD_HI: if (rd_valid) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/seg_cache_file.sv
// Segment register file: NSEG selectors with their hidden caches.
// Assumes at most one write per cycle, addressed by cw_seg.
module seg_cache_file
    import seg_pkg::*;
#(
    parameter int NSEG  = 6,
    parameter int SEG_W = 3,
    parameter int SEL_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cw_en,
    input  logic [SEG_W-1:0]           cw_seg,
    input  logic [SEL_W-1:0]           cw_sel,
    input  seg_cache_t                 cw_entry,
    output logic [NSEG-1:0][SEL_W-1:0] sel_q,
    output seg_cache_t [NSEG-1:0]      cache_q
);
    for (genvar g = 0; g < NSEG; g++) begin : g_reg
        // One register: selector and cache written together
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q[g]   <= '0;
                cache_q[g] <= '0;
            end else if (cw_en && (cw_seg == SEG_W'(g))) begin
                sel_q[g]   <= cw_sel;
                cache_q[g] <= cw_entry;
            end
        end
    end
endmodule

// File: rtl/seg_loader.sv
// Segment register descriptor loader top: six segment registers whose
// hidden caches are filled from the descriptor tables on a selector write.
// Assumes an external memory answering each held request with rd_valid.
module seg_loader
    import seg_pkg::*;
#(
    parameter int NSEG   = 6,
    parameter int SEG_W  = 3,
    parameter int SEL_W  = 16,
    parameter int ADDR_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        real_mode,
    input  logic                        wr_en,
    input  logic [SEG_W-1:0]            wr_seg,
    input  logic [SEL_W-1:0]            wr_sel,
    input  logic [ADDR_W-1:0]           gdt_base,
    input  logic [ADDR_W-1:0]           ldt_base,
    output logic                        rd_req,
    output logic [ADDR_W-1:0]           rd_addr,
    input  logic                        rd_valid,
    input  logic [31:0]                 rd_data,
    output logic                        busy,
    output logic                        fault,
    output logic [NSEG-1:0][SEL_W-1:0]  sel_o,
    output logic [NSEG-1:0][31:0]       base_o,
    output logic [NSEG-1:0][19:0]       limit_o,
    output logic [NSEG-1:0]             gran_o,
    output logic [NSEG-1:0]             db_o,
    output logic [NSEG-1:0]             app_o,
    output logic [NSEG-1:0][1:0]        dpl_o,
    output logic [NSEG-1:0][3:0]        type_o,
    output logic [NSEG-1:0]             present_o,
    output logic [NSEG-1:0][1:0]        ext_o
);
    logic                  cw_en;
    logic [SEG_W-1:0]      cw_seg;
    logic [SEL_W-1:0]      cw_sel;
    seg_cache_t            cw_entry;
    seg_cache_t [NSEG-1:0] cache_q;

    seg_fetch_ctrl #(.NSEG(NSEG), .SEG_W(SEG_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .real_mode (real_mode),
        .wr_en     (wr_en),
        .wr_seg    (wr_seg),
        .wr_sel    (wr_sel),
        .gdt_base  (gdt_base),
        .ldt_base  (ldt_base),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .busy      (busy),
        .fault     (fault),
        .cw_en     (cw_en),
        .cw_seg    (cw_seg),
        .cw_sel    (cw_sel),
        .cw_entry  (cw_entry)
    );

    seg_cache_file #(.NSEG(NSEG), .SEG_W(SEG_W), .SEL_W(SEL_W)) u_file (
        .clk      (clk),
        .rst_n    (rst_n),
        .cw_en    (cw_en),
        .cw_seg   (cw_seg),
        .cw_sel   (cw_sel),
        .cw_entry (cw_entry),
        .sel_q    (sel_o),
        .cache_q  (cache_q)
    );

    for (genvar g = 0; g < NSEG; g++) begin : g_out
        // Per-register field fan-out
        always_comb begin
            base_o[g]    = cache_q[g].base;
            limit_o[g]   = cache_q[g].limit;
            gran_o[g]    = cache_q[g].gran;
            db_o[g]      = cache_q[g].db;
            app_o[g]     = cache_q[g].app;
            dpl_o[g]     = cache_q[g].dpl;
            type_o[g]    = cache_q[g].typ;
            present_o[g] = cache_q[g].present;
            ext_o[g]     = cache_q[g].ext;
        end
    end
endmodule

// File: rtl/seg_loader_chk.sv
// Protocol checker for seg_loader, attached by bind.
// Assumes the default port widths of the top module.
module seg_loader_chk #(
    parameter int NSEG   = 6,
    parameter int SEG_W  = 3,
    parameter int SEL_W  = 16,
    parameter int ADDR_W = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       real_mode,
    input logic                       wr_en,
    input logic [SEG_W-1:0]           wr_seg,
    input logic                       rd_req,
    input logic [ADDR_W-1:0]          rd_addr,
    input logic                       rd_valid,
    input logic                       busy,
    input logic                       fault,
    input logic [NSEG-1:0][SEL_W-1:0] sel_o
);
    a_r5_req_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy);

    a_r3_second_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && $past(rd_req) && $past(rd_valid)) |-> (rd_addr == $past(rd_addr) + ADDR_W'(4)));

    a_r6_fault_keeps_sel: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $stable(sel_o));

    a_r6_fault_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !busy);

    a_r8_real_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && real_mode && !busy) |=> !busy);

    a_r10_bad_seg_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && (wr_seg >= SEG_W'(NSEG))) |=> !busy);
endmodule

bind seg_loader seg_loader_chk #(.NSEG(NSEG), .SEG_W(SEG_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .real_mode (real_mode),
    .wr_en     (wr_en),
    .wr_seg    (wr_seg),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_valid  (rd_valid),
    .busy      (busy),
    .fault     (fault),
    .sel_o     (sel_o)
);

// File: tb/seg_loader_tb.sv
// Self-checking bench: random and directed selector loads against a
// hashed descriptor memory with random read latency.
module seg_loader_tb;
    localparam int NSEG = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic real_mode = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] wr_seg = '0;
    logic [15:0] wr_sel = '0;
    logic [31:0] gdt_base = 32'h0001_0000;
    logic [31:0] ldt_base = 32'h0008_4000;
    logic rd_req;
    logic [31:0] rd_addr;
    logic rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic busy, fault;
    logic [NSEG-1:0][15:0] sel_o;
    logic [NSEG-1:0][31:0] base_o;
    logic [NSEG-1:0][19:0] limit_o;
    logic [NSEG-1:0] gran_o, db_o, app_o, present_o;
    logic [NSEG-1:0][1:0] dpl_o, ext_o;
    logic [NSEG-1:0][3:0] type_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit hung = 0;
    logic [15:0] exp_sel [NSEG];
    logic [63:0] exp_c [NSEG];

    always #2.5 clk = ~clk;

    seg_loader u_dut (
        .clk(clk), .rst_n(rst_n), .real_mode(real_mode), .wr_en(wr_en),
        .wr_seg(wr_seg), .wr_sel(wr_sel), .gdt_base(gdt_base), .ldt_base(ldt_base),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .fault(fault), .sel_o(sel_o), .base_o(base_o), .limit_o(limit_o),
        .gran_o(gran_o), .db_o(db_o), .app_o(app_o), .dpl_o(dpl_o), .type_o(type_o),
        .present_o(present_o), .ext_o(ext_o)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return ((a ^ 32'h5A17_C3E9) * 32'h9E37_79B1) + (a >> 5);
    endfunction

    // Cache image: {base, limit, g, db, s, dpl, type, p, ext}
    function automatic logic [63:0] desc_img(input logic [31:0] lo, input logic [31:0] hi);
        return {2'b00, hi[31:24], hi[7:0], lo[31:16], hi[19:16], lo[15:0],
                hi[23], hi[22], hi[12], hi[14:13], hi[11:8], hi[15], hi[21:20]};
    endfunction

    function automatic logic [63:0] real_img(input logic [15:0] s);
        return {2'b00, 12'h000, s, 4'h0, 20'h0FFFF, 1'b0, 1'b0, 1'b1, 2'b00, 4'b0011, 1'b1, 2'b00};
    endfunction

    function automatic logic [63:0] dut_img(input int i);
        return {2'b00, base_o[i], limit_o[i], gran_o[i], db_o[i], app_o[i],
                dpl_o[i], type_o[i], present_o[i], ext_o[i]};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NSEG; i++) begin
            check(req, {48'h0, sel_o[i]}, {48'h0, exp_sel[i]});
            check(req, dut_img(i), exp_c[i]);
        end
    endtask

    // Memory responder: random latency, one valid pulse per request
    initial begin
        int lat = 0;
        forever begin
            @(negedge clk);
            if (rd_valid) rd_valid = 1'b0;
            else if (rd_req) begin
                if (lat == 0) begin
                    rd_valid = 1'b1;
                    rd_data  = mem_word(rd_addr);
                    lat      = int'($urandom_range(0, 3));
                end else lat--;
            end
        end
    end

    // One load; spam=1 presents random writes on every busy cycle (R5)
    task automatic load(input logic [2:0] seg, input logic [15:0] sel, input bit rm, input bit spam);
        logic [31:0] a;
        logic [31:0] lo, hi;
        logic [63:0] img;
        bit exp_fault;
        int guard = 0;
        a = (sel[2] ? gdt_base : ldt_base) + {16'h0, sel[15:3], 3'b000};
        @(negedge clk);
        wr_en = 1'b1; wr_seg = seg; wr_sel = sel; real_mode = rm;
        @(negedge clk);
        wr_en = 1'b0;
        if (seg >= 3'(NSEG)) begin
            check("R10 busy", {63'h0, busy}, 64'h0);
            check("R10 rd_req", {63'h0, rd_req}, 64'h0);
            @(negedge clk);
            check_regs("R10 ignored");
            return;
        end
        if (rm) begin
            check("R8 busy", {63'h0, busy}, 64'h0);
            check("R8 rd_req", {63'h0, rd_req}, 64'h0);
            exp_sel[seg] = sel;
            exp_c[seg]   = real_img(sel);
            check_regs("R8 R9 real load");
            return;
        end
        check("R5 busy", {63'h0, busy}, 64'h1);
        if (rd_req) check("R2 addr", {32'h0, rd_addr}, {32'h0, a});
        while (busy) begin
            wr_en = spam; wr_seg = 3'($urandom_range(0, 7));
            wr_sel = 16'($urandom); real_mode = 1'($urandom_range(0, 1));
            @(negedge clk);
            guard++;
            if (guard > 1000) begin hung = 1; break; end
        end
        wr_en = 1'b0; real_mode = 1'b0;
        if (hung) begin n_cmp++; n_bad++; $display("FAIL R5 load hung actual=busy expected=idle"); return; end
        lo  = mem_word(a);
        hi  = mem_word(a + 32'd4);
        img = desc_img(lo, hi);
        exp_fault = !hi[15] || (hi[12] && !hi[11] && (sel[1:0] > hi[14:13]));
        check(hi[15] ? "R7 fault" : "R6 fault", {63'h0, fault}, {63'h0, exp_fault});
        if (!exp_fault) begin
            exp_sel[seg] = sel;
            exp_c[seg]   = img;
        end
        check_regs("R3 R4 R6 R7 R9 regs");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NSEG; i++) begin exp_sel[i] = '0; exp_c[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", {63'h0, busy}, 64'h0);
        check("R1 fault", {63'h0, fault}, 64'h0);
        check("R1 rd_req", {63'h0, rd_req}, 64'h0);
        check_regs("R1 reset");
        // Directed corners
        load(3'd2, 16'hB800, 1'b1, 1'b0);
        load(3'd5, 16'hFFFF, 1'b1, 1'b0);
        load(3'd6, 16'h0010, 1'b0, 1'b0);
        load(3'd7, 16'h1234, 1'b1, 1'b0);
        load(3'd0, 16'h0008, 1'b0, 1'b0);
        load(3'd1, 16'hFFFB, 1'b0, 1'b1);
        load(3'd4, 16'h0007, 1'b0, 1'b1);
        // Random mix
        for (int n = 0; n < 400 && !hung; n++) begin
            if (n % 50 == 0) begin
                gdt_base = {12'h0, 20'($urandom)} & 32'hFFFF_FFF8;
                ldt_base = 32'($urandom) & 32'hFFFF_FFF8;
            end
            load(3'($urandom_range(0, 7)), 16'($urandom),
                 ($urandom_range(0, 5) == 0), 1'($urandom_range(0, 1)));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule